// File: doc/BRIEF.md
# Multichannel PWM Bank

This block holds up to eight pulse-width channels behind one flat register port. Software writes the registers, and each channel then produces a repeating waveform. The output is at its active level for a programmed number of counts and at the inactive level for the rest of the period. Two timing enables come in, a crystal-oscillator tick and a bus-derived tick. Each pair of neighbouring channels picks one of them and divides it by a power of two. Each channel then divides the result again with an 8-bit prescaler before it steps its 16-bit period counter.

Every channel drives a level pin and an output-enable pin. A channel that is not enabled deasserts its output-enable, so the pad floats. A write to a channel's period or control register restarts that channel on the next cycle with the new values. The period already under way is not finished.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, every `pwm_oe` bit is low and every counter is at its start.
- R2: Register map. Pair clock word at 0x20 + 4*(ch/2). Gate word at 0x40, with gate bits at [ch] and stored bypass bits at [16+ch]. Enable word at 0x80. Channel control at 0x100 + 0x20*ch. Channel period at 0x104 + 0x20*ch. Reads return the stored fields (pair word keeps only bits [8:7] and [3:0]). Any other address reads zero.
- R3: Pair clock word: bits [8:7] equal to 0 select `osc_tick` and any nonzero value selects `bus_tick`. Bits [3:0] = M divide the selected tick by 2^M, and M above 8 acts as 8. Channels 2p and 2p+1 both use pair word p.
- R4: Control bits [7:0] = K divide the pair tick by K+1 before the period counter steps.
- R5: Period bits [31:16] = E give a period of E+1 counter steps. Bits [15:0] = A give A steps at the active level, starting from the counter's start. Control bit 8 set makes the active level high, and clear makes it low.
- R6: A >= E+1 holds the output at the active level for the whole period. A = 0 holds it at the inactive level.
- R7: `pwm_oe[ch]` follows enable bit ch one cycle after the enable write. A disabled channel is held at its start.
- R8: With the channel enabled and its gate bit clear, the counter and the output stay frozen.
- R9: A write to a channel's control or period register restarts its prescaler and counter at that clock edge. The following cycle is the first active step of a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator-rate count enable |
| bus_tick | input | 1 | Bus-rate count enable |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_o | output | NCH | Per-channel waveform level |
| pwm_oe | output | NCH | Per-channel output-enable |

## Verification
The waveform is measured by counting active-level cycles over exactly one full period. This count does not depend on where the shared divider happens to be in its cycle. The vectors vary the period, the active length, the prescaler, the divider (including a clamped value of 12), the tick source and the polarity, so an error in any one stage changes the count. The duty extremes, a write that restarts a channel in the middle of its inactive phase, gate freezing and pair sharing are each tried separately. Sharing is shown by moving the other pair's divider and seeing no change on the channel under test.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_tick,
  input  logic           bus_tick,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           reg_we,
  output logic [31:0]    reg_rdata,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] pwm_oe
);
  localparam int NPAIR     = (NCH + 1) / 2;
  localparam int CFG_BASE  = 'h20;
  localparam int GATE_ADDR = 'h40;
  localparam int EN_ADDR   = 'h80;
  localparam int CH_BASE   = 'h100;
  localparam int CH_STRIDE = 'h20;
  localparam int BYP_LSB   = 16;

  logic [NPAIR-1:0][5:0]  cfg_q;
  logic [NCH-1:0]         gate_q, byp_q, en_q;
  logic [NCH-1:0][8:0]    ctl_q;
  logic [NCH-1:0][31:0]   per_q;
  logic [NCH-1:0][7:0]    pre_q;
  logic [NCH-1:0][15:0]   cnt_q;
  logic [NPAIR-1:0][7:0]  div_cnt;
  logic [NPAIR-1:0]       pair_tick;
  logic [NCH-1:0]         ctl_we, per_we, pol_w;

  wire gate_we = reg_we && (reg_addr == AW'(GATE_ADDR));
  wire en_we   = reg_we && (reg_addr == AW'(EN_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= '0;
      byp_q  <= '0;
      en_q   <= '0;
    end else begin
      if (gate_we) begin
        gate_q <= reg_wdata[NCH-1:0];
        byp_q  <= reg_wdata[BYP_LSB +: NCH];
      end
      if (en_we) en_q <= reg_wdata[NCH-1:0];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic       sel;
    logic [3:0] m;
    logic [8:0] span;
    logic [7:0] mask;
    wire cfg_we = reg_we && (reg_addr == AW'(CFG_BASE + 4*p));

    assign sel  = (cfg_q[p][5:4] != 2'b00) ? bus_tick : osc_tick;
    assign m    = (cfg_q[p][3:0] > 4'd8) ? 4'd8 : cfg_q[p][3:0];
    assign span = (9'd1 << m) - 9'd1;
    assign mask = span[7:0];
    assign pair_tick[p] = sel && ((div_cnt[p] & mask) == mask);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[p]   <= '0;
        div_cnt[p] <= '0;
      end else begin
        if (cfg_we) cfg_q[p] <= {reg_wdata[8:7], reg_wdata[3:0]};
        if (sel) div_cnt[p] <= div_cnt[p] + 8'd1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [15:0] entire = per_q[c][31:16];
    wire [15:0] act    = per_q[c][15:0];
    wire run     = en_q[c] && gate_q[c] && pair_tick[c/2];
    wire pre_hit = (pre_q[c] == ctl_q[c][7:0]);

    assign ctl_we[c] = reg_we && (reg_addr == AW'(CH_BASE + CH_STRIDE*c));
    assign per_we[c] = reg_we && (reg_addr == AW'(CH_BASE + CH_STRIDE*c + 4));
    assign pol_w[c]  = ctl_q[c][8];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[c] <= '0;
        per_q[c] <= '0;
      end else begin
        if (ctl_we[c]) ctl_q[c] <= reg_wdata[8:0];
        if (per_we[c]) per_q[c] <= reg_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !en_q[c] || ctl_we[c] || per_we[c]) begin
        pre_q[c] <= '0;
        cnt_q[c] <= '0;
      end else if (run) begin
        if (pre_hit) begin
          pre_q[c] <= '0;
          cnt_q[c] <= (cnt_q[c] >= entire) ? 16'd0 : cnt_q[c] + 16'd1;
        end else begin
          pre_q[c] <= pre_q[c] + 8'd1;
        end
      end
    end

    assign pwm_o[c]  = (cnt_q[c] < act) ? pol_w[c] : ~pol_w[c];
    assign pwm_oe[c] = en_q[c];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(GATE_ADDR)) begin
      reg_rdata[NCH-1:0]         = gate_q;
      reg_rdata[BYP_LSB +: NCH]  = byp_q;
    end
    if (reg_addr == AW'(EN_ADDR)) reg_rdata[NCH-1:0] = en_q;
    for (int p = 0; p < NPAIR; p++)
      if (reg_addr == AW'(CFG_BASE + 4*p))
        reg_rdata = {23'd0, cfg_q[p][5:4], 3'd0, cfg_q[p][3:0]};
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(CH_BASE + CH_STRIDE*c))     reg_rdata = {23'd0, ctl_q[c]};
      if (reg_addr == AW'(CH_BASE + CH_STRIDE*c + 4)) reg_rdata = per_q[c];
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [15:0]          wdata_lo,
  input logic [NCH-1:0]       pwm_o,
  input logic [NCH-1:0]       pwm_oe,
  input logic [NCH-1:0]       en_q,
  input logic [NCH-1:0]       gate_q,
  input logic [NCH-1:0]       pol_w,
  input logic [NCH-1:0][31:0] per_q,
  input logic [NCH-1:0][15:0] cnt_q
);
  a_r7_oe_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'('h80)) |=> (pwm_oe == $past(wdata_lo[NCH-1:0])));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r9_restart_active: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'('h104 + 'h20*c) && wdata_lo != 16'd0) |=> (pwm_o[c] == pol_w[c]));

    a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q[c][15:0] == 16'd0) |-> (pwm_o[c] != pol_w[c]));

    a_r6_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, per_q[c][15:0]} > {1'b0, per_q[c][31:16]}) |-> (pwm_o[c] == pol_w[c]));

    a_r8_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] && !gate_q[c] && !reg_we) |=> $stable(cnt_q[c]));

    a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[c] <= per_q[c][31:16]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wdata_lo(reg_wdata[15:0]), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
  .en_q(en_q), .gate_q(gate_q), .pol_w(pol_w), .per_q(per_q), .cnt_q(cnt_q)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NCH = 8;
  localparam int AW  = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           osc_tick = 1'b1;
  logic           bus_tick = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic           reg_we = 1'b0;
  logic [31:0]    reg_rdata;
  logic [NCH-1:0] pwm_o, pwm_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm_bank #(.NCH(NCH), .AW(AW)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  always #2 clk = ~clk;

  initial begin : bus_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == 2) ? 0 : ph + 1;
      bus_tick = (ph == 0);
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam int NV = 7;
  localparam int V_CH  [NV] = '{0, 3, 4, 5, 7, 2, 6};
  localparam int V_E   [NV] = '{9, 4, 7, 3, 5, 5, 2};
  localparam int V_A   [NV] = '{3, 2, 5, 1, 6, 0, 1};
  localparam int V_K   [NV] = '{0, 2, 0, 1, 0, 0, 0};
  localparam int V_M   [NV] = '{0, 0, 2, 1, 0, 0, 12};
  localparam int V_SRC [NV] = '{0, 0, 0, 1, 0, 0, 0};
  localparam int V_POL [NV] = '{1, 1, 0, 1, 1, 1, 1};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = AW'(a);
    reg_wdata = d;
    reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic meas(input int ch, input int n, input logic lvl, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o[ch] == lvl) hits++;
    end
  endtask

  task automatic setup(input int ch, input int e, input int a, input int k,
                       input int pol, input int m, input int src);
    wr('h20 + 4 * (ch / 2), (src << 7) | m);
    wr('h100 + 'h20 * ch, (pol << 8) | k);
    wr('h104 + 'h20 * ch, (e << 16) | a);
  endtask

  initial begin
    logic [31:0] d;
    int hits, t, p, h, n;
    logic lvl;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 oe", pwm_oe, 0);
    rd('h40, d);  chk("R1 gate", d, 0);
    rd('h80, d);  chk("R1 enable", d, 0);
    rd('h20, d);  chk("R1 cfg", d, 0);
    rd('h1E4, d); chk("R1 period ch7", d, 0);

    // R2: readback and unmapped reads
    wr('h124, 'h1234_5678);
    rd('h124, d); chk("R2 period readback", d, 'h1234_5678);
    wr('h24, 'hFFFF);
    rd('h24, d);  chk("R2 cfg mask", d, 'h18F);
    wr('h40, 'h00FF_00FF);
    rd('h40, d);  chk("R2 gate/bypass", d, 'h00FF_00FF);
    rd('h44, d);  chk("R2 unmapped", d, 0);
    rd('h102, d); chk("R2 unaligned", d, 0);
    wr('h24, 0);

    // R3 R4 R5 R6: vector table, duty measured over one full period
    for (int v = 0; v < NV; v++) begin
      wr('h80, 0);
      setup(V_CH[v], V_E[v], V_A[v], V_K[v], V_POL[v],
            (V_M[v] > 15) ? 15 : V_M[v], V_SRC[v]);
      wr('h80, 1 << V_CH[v]);
      t = (V_K[v] + 1) * (1 << ((V_M[v] > 8) ? 8 : V_M[v])) * (V_SRC[v] != 0 ? 3 : 1);
      p = (V_E[v] + 1) * t;
      h = ((V_A[v] > V_E[v] + 1) ? V_E[v] + 1 : V_A[v]) * t;
      repeat (2 * p + 4) @(negedge clk);
      meas(V_CH[v], p, V_POL[v][0], hits);
      chk($sformatf("R5 vector %0d (R3 R4 R6)", v), hits, h);
      chk($sformatf("R7 vector %0d oe", v), pwm_oe, 1 << V_CH[v]);
    end

    // R3: pair 0 shared by channel 1; pair 1 has no effect on it
    wr('h80, 0);
    setup(1, 3, 2, 0, 1, 1, 0);
    wr('h80, 'h2);
    repeat (20) @(negedge clk);
    meas(1, 8, 1'b1, hits); chk("R3 ch1 on pair0", hits, 4);
    wr('h24, 3);
    repeat (4) @(negedge clk);
    meas(1, 8, 1'b1, hits); chk("R3 pair1 ignored by ch1", hits, 4);

    // R9: restart mid-period
    wr('h80, 0);
    setup(0, 9, 5, 0, 1, 0, 0);
    wr('h80, 1);
    n = 0;
    while (pwm_o[0] != 1'b1 && n < 50) begin @(negedge clk); n++; end
    while (pwm_o[0] != 1'b0 && n < 50) begin @(negedge clk); n++; end
    wr('h104, (9 << 16) | 5);
    n = 0;
    while (pwm_o[0] == 1'b1 && n < 20) begin n++; @(negedge clk); end
    chk("R9 active run after restart", n, 5);

    // R8: gate cleared freezes output
    setup(0, 3, 2, 0, 1, 0, 0);
    repeat (7) @(negedge clk);
    wr('h40, 0);
    lvl = pwm_o[0];
    meas(0, 30, lvl, hits);
    chk("R8 frozen output", hits, 30);
    chk("R8 oe kept", pwm_oe[0], 1);

    // R7: disable drops oe
    wr('h80, 0);
    chk("R7 oe after disable", pwm_oe, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule